// File: doc/BRIEF.md
# Flash Write Buffer Controller

This block models how a small microcontroller writes its program memory. The CPU fills eight one-byte staging registers with short table writes. Each table write copies a byte-wide data latch into the staging slot picked by the low three bits of a table pointer. The flash array is not touched at this stage. Once the block is full, software writes a two-byte key to a key register and then writes the control register with the start bit set. This begins a long write, which copies all eight staged bytes into one aligned 8-byte block of the array in a single step.

A down-counting timer sets the length of the long write, counted in clock cycles. A stall output holds the CPU for the whole cycle. When the timer runs out, the array block is updated, the staging registers clear and the stall drops. A combinational read port lets the array contents be checked afterwards. A start attempt made with write-enable clear raises a sticky error flag.

Top module: `flash_wbuf`

## Requirements
- R1: After reset, `stall` and `wr_err` are 0, every array byte reads FFh, and all eight staging registers hold 00h.
- R2: A table write (`tbl_wr` high with `bus_we` low) copies the data latch into the staging register indexed by pointer bits [2:0]. It never changes the array.
- R3: A long write updates all eight bytes of the aligned block whose index is pointer bits [ADDR_W-1:3] at the time of the start. Every other array byte keeps its value.
- R4: A long write starts only when three writes arrive in order with no other write between them: 55h to the key register (`bus_sel`=3), then AAh to the key register, then a control write (`bus_sel`=2) with bit 1 (start) set. Idle cycles between these writes are allowed.
- R5: Any other bus write or table write that falls between the steps of R4 returns the key sequence to idle, and the following start bit is ignored.
- R6: The starting control write must itself have bit 7 (program-memory select) = 1, bit 6 (config-space select) = 0 and bit 2 (write-enable) = 1. If any of these is wrong, no long write starts.
- R7: `stall` rises in the cycle after the starting control write and stays high for exactly PROG_CYCLES cycles. The array shows the new block in the cycle in which `stall` falls.
- R8: When a long write completes, all eight staging registers are cleared to 00h.
- R9: When control bit 0 (post-increment) is set, each table write also advances the table pointer by one. The pointer is loaded by a bus write with `bus_sel`=1, and the latch by a bus write with `bus_sel`=0.
- R10: A control write with bit 1 set and bit 2 clear sets `wr_err`. The flag stays set until reset, and no long write starts.
- R11: While `stall` is high, all bus writes and table writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register-bus write strobe |
| bus_sel | input | 2 | Register select: 0 latch, 1 pointer, 2 control, 3 key |
| bus_wdata | input | 8 | Register-bus write data |
| tbl_wr | input | 1 | Table write strobe; ignored when `bus_we` is high in the same cycle |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr`, combinational |
| stall | output | 1 | High for the whole long write |
| wr_err | output | 1 | Sticky start-with-write-enable-clear error |

## Verification
Bus and table writes take effect at the edge that samples them. A valid start therefore shows `stall` high at the next falling edge. The bench counts falling edges while `stall` is high and expects exactly PROG_CYCLES. Array contents are read only after `stall` has been seen low, because the commit lands on the edge where `stall` falls. The combinational read port lets the monitor set `rd_addr` on a falling edge and compare `rd_data` a short time later within the same half-cycle. Rejected start attempts are checked at the falling edge that follows the control write, which is the first point where a started cycle would show `stall`.

// File: rtl/flash_wbuf.sv
module flash_wbuf #(
  parameter int ADDR_W      = 8,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_sel,
  input  logic [7:0]        bus_wdata,
  input  logic              tbl_wr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              stall,
  output logic              wr_err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(PROG_CYCLES + 1);
  localparam logic [1:0] SEL_LATCH = 2'd0;
  localparam logic [1:0] SEL_PTR   = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_KEY   = 2'd3;

  typedef enum logic [1:0] {K_IDLE, K_FIRST, K_ARMED} key_t;

  key_t              key;
  logic [7:0]        latch;
  logic [ADDR_W-1:0] ptr;
  logic              post_inc;
  logic              busy;
  logic [TW-1:0]     tmr;
  logic [ADDR_W-4:0] blk;
  logic [7:0]        hold [8];
  logic [7:0]        mem  [DEPTH];

  wire bus_ok  = bus_we && !busy;
  wire tw_ok   = tbl_wr && !bus_we && !busy;
  wire ctrl_wr = bus_ok && bus_sel == SEL_CTRL;
  wire wr_req  = ctrl_wr && bus_wdata[1];
  wire cfg_ok  = bus_wdata[7] && !bus_wdata[6] && bus_wdata[2];
  wire start   = wr_req && cfg_ok && key == K_ARMED;
  wire done    = busy && tmr == '0;
  wire key55   = bus_ok && bus_sel == SEL_KEY && bus_wdata == 8'h55;
  wire keyAA   = bus_ok && bus_sel == SEL_KEY && bus_wdata == 8'hAA;

  assign stall   = busy;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key      <= K_IDLE;
      latch    <= '0;
      ptr      <= '0;
      post_inc <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      if (bus_ok || tw_ok) begin
        if (key55)                     key <= K_FIRST;
        else if (keyAA && key == K_FIRST) key <= K_ARMED;
        else                           key <= K_IDLE;
      end
      if (bus_ok && bus_sel == SEL_LATCH) latch <= bus_wdata;
      if (bus_ok && bus_sel == SEL_PTR)   ptr <= bus_wdata[ADDR_W-1:0];
      else if (tw_ok && post_inc)         ptr <= ptr + 1'b1;
      if (ctrl_wr) post_inc <= bus_wdata[0];
      if (wr_req && !bus_wdata[2]) wr_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tmr  <= '0;
      blk  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      tmr  <= TW'(PROG_CYCLES - 1);
      blk  <= ptr[ADDR_W-1:3];
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      tmr  <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) hold[i] <= '0;
    end else if (done) begin
      for (int i = 0; i < 8; i++) hold[i] <= '0;
    end else if (tw_ok) begin
      hold[ptr[2:0]] <= latch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (done) begin
      for (int i = 0; i < 8; i++) mem[{blk, 3'(i)}] <= hold[i];
    end
  end
endmodule

// File: rtl/flash_wbuf_chk.sv
module flash_wbuf_chk #(
  parameter int ADDR_W      = 8,
  parameter int PROG_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [1:0]        bus_sel,
  input logic [7:0]        bus_wdata,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              stall,
  input logic              wr_err
);
  int cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= 0;
    else if (stall) cnt <= cnt + 1;
    else            cnt <= 0;
  end

  AST_STALL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> cnt < PROG_CYCLES); // R7
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> cnt == PROG_CYCLES); // R7
  AST_START_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(bus_we && bus_sel == 2'd2 && bus_wdata[1] && bus_wdata[2]
                           && bus_wdata[7] && !bus_wdata[6])); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err); // R10
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel == 2'd2 && bus_wdata[1] && !bus_wdata[2] && !stall) |=> !stall); // R10
  AST_ARRAY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_addr) && !$fell(stall)) |-> $stable(rd_data)); // R2
endmodule

bind flash_wbuf flash_wbuf_chk #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
  .rd_addr(rd_addr), .rd_data(rd_data), .stall(stall), .wr_err(wr_err)
);

// File: tb/test_flash_wbuf.sv
module test_flash_wbuf;
  localparam int AW = 8;
  localparam int P  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_sel = '0;
  logic [7:0]    bus_wdata = '0;
  logic          tbl_wr = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          stall;
  logic          wr_err;

  int ncheck = 0;
  int nfail  = 0;

  typedef struct { logic [AW-1:0] a; logic [7:0] d; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  flash_wbuf #(.ADDR_W(AW), .PROG_CYCLES(P)) i_flash_wbuf (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .tbl_wr(tbl_wr), .rd_addr(rd_addr), .rd_data(rd_data), .stall(stall), .wr_err(wr_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    ncheck++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic tw();
    @(negedge clk); tbl_wr = 1'b1;
    @(negedge clk); tbl_wr = 1'b0;
  endtask

  task automatic unlock();
    bus(2'd3, 8'h55);
    bus(2'd3, 8'hAA);
  endtask

  task automatic wait_prog(input string tag);
    int n = 0;
    while (stall) begin n++; @(negedge clk); end
    chk(tag, n, P);
  endtask

  task automatic wait_idle();
    while (stall) @(negedge clk);
  endtask

  task automatic expect_b(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    item_t it;
    it.a = a; it.d = d; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        rd_addr = it.a;
        #2;
        chk(it.tag, rd_data, it.d);
      end
    end
  end

  initial begin
    #(20 * 20000);
    nfail++;
    $display("FAIL watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stall", stall, 0);
    chk("R1 err", wr_err, 0);
    expect_b(8'h00, 8'hFF, "R1 array");
    expect_b(8'h5A, 8'hFF, "R1 array");
    expect_b(8'hFF, 8'hFF, "R1 array");
    drain();

    // R9 post-increment fill, R2 short writes
    bus(2'd2, 8'h85);
    bus(2'd1, 8'h10);
    for (int i = 0; i < 8; i++) begin
      bus(2'd0, 8'(8'h11 * (i + 1)));
      tw();
    end
    expect_b(8'h10, 8'hFF, "R2 short write");
    expect_b(8'h17, 8'hFF, "R2 short write");
    drain();
    bus(2'd1, 8'h14);
    unlock();
    bus(2'd2, 8'h87);
    chk("R4 start", stall, 1);
    wait_prog("R7 stall length");
    for (int i = 0; i < 8; i++) expect_b(8'(8'h10 + i), 8'(8'h11 * (i + 1)), "R9 R3 block");
    expect_b(8'h0F, 8'hFF, "R3 neighbour");
    expect_b(8'h18, 8'hFF, "R3 neighbour");
    drain();

    // R8 staging cleared after completion
    bus(2'd2, 8'h84);
    bus(2'd1, 8'h22);
    bus(2'd0, 8'hC3);
    tw();
    unlock();
    bus(2'd2, 8'h86);
    wait_prog("R7 stall length");
    for (int i = 0; i < 8; i++)
      expect_b(8'(8'h20 + i), (i == 2) ? 8'hC3 : 8'h00, "R8 cleared");
    drain();

    // R5 broken key sequences
    bus(2'd0, 8'h99);
    tw();
    bus(2'd3, 8'h55); bus(2'd0, 8'h99); bus(2'd3, 8'hAA); bus(2'd2, 8'h86);
    chk("R5 gap after first key", stall, 0);
    bus(2'd3, 8'h55); bus(2'd3, 8'hAA); bus(2'd0, 8'h99); bus(2'd2, 8'h86);
    chk("R5 gap after second key", stall, 0);
    bus(2'd3, 8'hAA); bus(2'd2, 8'h86);
    chk("R5 second key alone", stall, 0);
    bus(2'd3, 8'h55); bus(2'd3, 8'hAA); tw(); bus(2'd2, 8'h86);
    chk("R5 table write between", stall, 0);

    // R6 field conditions
    unlock(); bus(2'd2, 8'h06);
    chk("R6 program select clear", stall, 0);
    unlock(); bus(2'd2, 8'hC6);
    chk("R6 config select set", stall, 0);
    expect_b(8'h22, 8'hC3, "R5 R6 array kept");
    drain();

    // R4 proper sequence
    unlock(); bus(2'd2, 8'h86);
    chk("R4 start", stall, 1);
    wait_prog("R7 stall length");
    expect_b(8'h22, 8'h99, "R4 commit");
    expect_b(8'h20, 8'h00, "R4 commit");
    drain();

    // R11 writes ignored during stall
    bus(2'd1, 8'h30);
    bus(2'd0, 8'h5E);
    tw();
    unlock(); bus(2'd2, 8'h86);
    bus(2'd1, 8'h40);
    bus(2'd0, 8'h77);
    tw();
    wait_idle();
    expect_b(8'h30, 8'h5E, "R11 first commit");
    expect_b(8'h40, 8'hFF, "R11 first commit");
    drain();
    tw();
    unlock(); bus(2'd2, 8'h86);
    wait_prog("R7 stall length");
    expect_b(8'h30, 8'h5E, "R11 latch kept");
    expect_b(8'h31, 8'h00, "R11 staging kept");
    expect_b(8'h40, 8'hFF, "R11 pointer kept");
    drain();

    // R10 error flag
    chk("R10 err before", wr_err, 0);
    unlock(); bus(2'd2, 8'h82);
    chk("R10 no start", stall, 0);
    chk("R10 err set", wr_err, 1);
    unlock(); bus(2'd2, 8'h86);
    wait_idle();
    chk("R10 err sticky", wr_err, 1);
    expect_b(8'h30, 8'h00, "R10 array after valid cycle");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end
endmodule